// File: doc/BRIEF.md
# Adapter Interrupt Status and Enable Controller

This block holds the interrupt state of a storage adapter. Two internal event strobes, one for "completions have been posted" and one for "a message has been posted", set sticky bits in a status register. Software reads that register and clears bits by writing ones to it. A separate enable register gates which status bits may raise an interrupt. Software replaces the enable register with a single full-word write.

The interrupt leaves the block in one of two forms, chosen by a mode input. In level mode, a line stays high for as long as any enabled status bit is set. In message mode, that line stays low. Instead, a one-cycle notification pulse goes out after every update that leaves an enabled bit pending. Every write to the status register also sends a one-cycle retry strobe to the logic that drains queued completions. The block also provides the read data for its register window, including a command-status word that it passes through from outside.

Registers are 32-bit words, accessed only as whole words at byte offsets. Bit 0 is the least significant bit of the little-endian word.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After synchronous reset the status and enable registers are 0, `irq_level`, `irq_msg_pulse` and `drain_retry` are low, and both registers read back as 0.
- R2: A `cmp_event` cycle sets status bit 0 (value 0x1). A `msg_event` cycle sets status bit 8 (value 0x100). No other bit changes, and bits already set stay set.
- R3: A write to offset 0x00 (status) clears every status bit that is 1 in the written word and leaves the other bits alone. If an event arrives in the same cycle, the event's bit ends up set.
- R4: A write to offset 0x04 (enable) replaces all 32 enable bits with the written word.
- R5: In level mode (`msi_mode`=0), `irq_level` is high exactly when (status AND enable) is nonzero. It reflects a register update from the cycle after the clock edge that performed that update.
- R6: In message mode (`msi_mode`=1), `irq_level` stays low. `irq_msg_pulse` is high for one cycle after each update (event, status write or enable write) whose result has (status AND enable) nonzero, and it stays low after any other cycle.
- R7: Every status-register write raises `drain_retry` for exactly one cycle after the write edge, whatever the written value.
- R8: Read data is combinational from `reg_addr`: 0x00 gives status, 0x04 gives enable, 0x08 gives `cmd_status_i`, and any other offset gives 0.
- R9: Writes to offset 0x08 or to any unknown offset change neither register and produce no pulse.
- R10: An offset whose two low bits are not both 0 counts as unknown for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cmd_status_i | input | 32 | Command-status word served at offset 0x08 |
| cmp_event | input | 1 | Completions-posted event |
| msg_event | input | 1 | Message-posted event |
| msi_mode | input | 1 | 1 selects message notification, 0 selects the level line |
| irq_level | output | 1 | Level interrupt line |
| irq_msg_pulse | output | 1 | One-cycle message notification |
| drain_retry | output | 1 | One-cycle retry request to the completion-drain logic |

## Verification
If a status or enable bit is held wrongly, it shows at the read port on the very next access. It also shows on `irq_level` in the first cycle after the edge that should have changed it. A bad pending computation in message mode causes a missing or extra notification in the cycle right after the update. The sweep therefore applies every event pair under several enable patterns, in both modes. After each step it checks both the outputs and the read-back registers, so any error is caught within one cycle.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CMDST  = 8'h08;

    localparam int BIT_CMP = 0;
    localparam int BIT_MSG = 8;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_CMDST  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     sts_clr;
        logic     en_load;
    } reg_access_s;

    function automatic reg_sel_e offset_to_sel(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] o_sts,
        input logic [ADDR_W-1:0] o_en,
        input logic [ADDR_W-1:0] o_cmd
    );
        if (a[1:0] != 2'b00) return SEL_NONE;
        if (a == o_sts)      return SEL_STATUS;
        if (a == o_en)       return SEL_ENABLE;
        if (a == o_cmd)      return SEL_CMDST;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_stat_pkg::*;
#(
    parameter int                AW      = ADDR_W,
    parameter logic [AW-1:0]     STS_OFS = OFS_STATUS,
    parameter logic [AW-1:0]     EN_OFS  = OFS_ENABLE,
    parameter logic [AW-1:0]     CMD_OFS = OFS_CMDST
) (
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    output reg_access_s   acc
);
    reg_sel_e sel;

    always_comb begin
        sel         = offset_to_sel(addr, STS_OFS, EN_OFS, CMD_OFS);
        acc.sel     = sel;
        acc.sts_clr = wr_en && (sel == SEL_STATUS);
        acc.en_load = wr_en && (sel == SEL_ENABLE);
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int DW      = 32,
    parameter int CMP_POS = 0,
    parameter int MSG_POS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_ev,
    input  logic          msg_ev,
    input  logic          sts_clr,
    input  logic          en_load,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] sts_q,
    output logic [DW-1:0] en_q,
    output logic          update,
    output logic          pend_next
);
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;
    logic [DW-1:0] sts_d;
    logic [DW-1:0] en_d;

    for (genvar b = 0; b < DW; b++) begin : g_set
        if (b == CMP_POS && b == MSG_POS) begin : g_both
            assign set_vec[b] = cmp_ev | msg_ev;
        end else if (b == CMP_POS) begin : g_cmp
            assign set_vec[b] = cmp_ev;
        end else if (b == MSG_POS) begin : g_msg
            assign set_vec[b] = msg_ev;
        end else begin : g_none
            assign set_vec[b] = 1'b0;
        end
    end

    always_comb begin
        clr_vec   = sts_clr ? wdata : '0;
        sts_d     = (sts_q & ~clr_vec) | set_vec;
        en_d      = en_load ? wdata : en_q;
        update    = cmp_ev | msg_ev | sts_clr | en_load;
        pend_next = |(sts_d & en_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
        end
    end
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver (
    input  logic clk,
    input  logic rst,
    input  logic msi_mode,
    input  logic pend_now,
    input  logic update,
    input  logic pend_next,
    input  logic sts_clr,
    output logic irq_level,
    output logic msg_pulse,
    output logic drain_retry
);
    always_ff @(posedge clk) begin
        if (rst) begin
            msg_pulse   <= 1'b0;
            drain_retry <= 1'b0;
        end else begin
            msg_pulse   <= msi_mode && update && pend_next;
            drain_retry <= sts_clr;
        end
    end

    assign irq_level = !msi_mode && pend_now;
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
    import irq_stat_pkg::*;
#(
    parameter int DW      = REG_W,
    parameter int AW      = ADDR_W,
    parameter int CMP_POS = BIT_CMP,
    parameter int MSG_POS = BIT_MSG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr_en,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] cmd_status_i,
    input  logic          cmp_event,
    input  logic          msg_event,
    input  logic          msi_mode,
    output logic          irq_level,
    output logic          irq_msg_pulse,
    output logic          drain_retry
);
    reg_access_s   acc;
    logic [DW-1:0] sts_q;
    logic [DW-1:0] en_q;
    logic          update;
    logic          pend_next;
    logic          pend_now;

    irq_reg_decode #(
        .AW      (AW),
        .STS_OFS (AW'(OFS_STATUS)),
        .EN_OFS  (AW'(OFS_ENABLE)),
        .CMD_OFS (AW'(OFS_CMDST))
    ) u_dec (
        .addr  (reg_addr),
        .wr_en (reg_wr_en),
        .acc   (acc)
    );

    irq_status_reg #(
        .DW      (DW),
        .CMP_POS (CMP_POS),
        .MSG_POS (MSG_POS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmp_ev    (cmp_event),
        .msg_ev    (msg_event),
        .sts_clr   (acc.sts_clr),
        .en_load   (acc.en_load),
        .wdata     (reg_wdata),
        .sts_q     (sts_q),
        .en_q      (en_q),
        .update    (update),
        .pend_next (pend_next)
    );

    assign pend_now = |(sts_q & en_q);

    irq_deliver u_out (
        .clk         (clk),
        .rst         (rst),
        .msi_mode    (msi_mode),
        .pend_now    (pend_now),
        .update      (update),
        .pend_next   (pend_next),
        .sts_clr     (acc.sts_clr),
        .irq_level   (irq_level),
        .msg_pulse   (irq_msg_pulse),
        .drain_retry (drain_retry)
    );

    always_comb begin
        unique case (acc.sel)
            SEL_STATUS: reg_rdata = sts_q;
            SEL_ENABLE: reg_rdata = en_q;
            SEL_CMDST:  reg_rdata = cmd_status_i;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_stat_ctrl_chk.sv
module irq_stat_ctrl_chk
    import irq_stat_pkg::*;
#(
    parameter int DW      = REG_W,
    parameter int AW      = ADDR_W,
    parameter int CMP_POS = BIT_CMP,
    parameter int MSG_POS = BIT_MSG
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr_en,
    input logic [DW-1:0] reg_wdata,
    input logic          cmp_event,
    input logic          msg_event,
    input logic          msi_mode,
    input logic          irq_level,
    input logic          irq_msg_pulse,
    input logic          drain_retry,
    input logic [DW-1:0] sts_q,
    input logic [DW-1:0] en_q
);
    logic wr_sts;
    logic wr_en_reg;
    assign wr_sts    = reg_wr_en && (reg_addr == AW'(OFS_STATUS));
    assign wr_en_reg = reg_wr_en && (reg_addr == AW'(OFS_ENABLE));

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sts_q == '0 && en_q == '0 && !irq_msg_pulse && !drain_retry));

    a_r2_cmp_sets_bit: assert property (@(posedge clk) disable iff (rst)
        cmp_event |=> sts_q[CMP_POS]);

    a_r2_msg_sets_bit: assert property (@(posedge clk) disable iff (rst)
        msg_event |=> sts_q[MSG_POS]);

    a_r3_write_one_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && !cmp_event && !msg_event) |=> ((sts_q & $past(reg_wdata)) == '0));

    a_r4_enable_replaced: assert property (@(posedge clk) disable iff (rst)
        wr_en_reg |=> (en_q == $past(reg_wdata)));

    a_r5_level_tracks: assert property (@(posedge clk) disable iff (rst)
        !msi_mode |-> (irq_level == (|(sts_q & en_q))));

    a_r6_line_quiet_in_msg: assert property (@(posedge clk) disable iff (rst)
        msi_mode |-> !irq_level);

    a_r6_pulse_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq_msg_pulse |-> (|(sts_q & en_q)));

    a_r7_retry_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr_sts |=> drain_retry);

    a_r7_retry_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !wr_sts |=> !drain_retry);
endmodule

bind irq_stat_ctrl irq_stat_ctrl_chk #(
    .DW      (DW),
    .AW      (AW),
    .CMP_POS (CMP_POS),
    .MSG_POS (MSG_POS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_addr      (reg_addr),
    .reg_wr_en     (reg_wr_en),
    .reg_wdata     (reg_wdata),
    .cmp_event     (cmp_event),
    .msg_event     (msg_event),
    .msi_mode      (msi_mode),
    .irq_level     (irq_level),
    .irq_msg_pulse (irq_msg_pulse),
    .drain_retry   (drain_retry),
    .sts_q         (sts_q),
    .en_q          (en_q)
);

// File: tb/irq_stat_ctrl_test.sv
`timescale 1ns/1ps
module irq_stat_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] cmd_status_i;
    logic        cmp_event;
    logic        msg_event;
    logic        msi_mode;
    logic        irq_level;
    logic        irq_msg_pulse;
    logic        drain_retry;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_sts;
    logic [31:0] m_en;
    logic        e_pulse;
    logic        e_drain;

    always #2 clk = ~clk;

    irq_stat_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .reg_addr      (reg_addr),
        .reg_wr_en     (reg_wr_en),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .cmd_status_i  (cmd_status_i),
        .cmp_event     (cmp_event),
        .msg_event     (msg_event),
        .msi_mode      (msi_mode),
        .irq_level     (irq_level),
        .irq_msg_pulse (irq_msg_pulse),
        .drain_retry   (drain_retry)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #0.5;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    // One bus/event cycle, then checks of every output against the model.
    task automatic step(input logic c, input logic m, input logic w,
                        input logic [7:0] a, input logic [31:0] d, input string req);
        logic upd;
        @(negedge clk);
        cmp_event = c; msg_event = m; reg_wr_en = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmp_event = 1'b0; msg_event = 1'b0; reg_wr_en = 1'b0;
        upd = c | m;
        if (w && a == 8'h00) begin
            m_sts = m_sts & ~d;
            upd = 1'b1;
        end
        if (w && a == 8'h04) begin
            m_en = d;
            upd = 1'b1;
        end
        if (c) m_sts[0] = 1'b1;
        if (m) m_sts[8] = 1'b1;
        e_pulse = msi_mode && upd && (|(m_sts & m_en));
        e_drain = w && (a == 8'h00);
        #0.5;
        check(irq_level === (!msi_mode && (|(m_sts & m_en))),
              msi_mode ? "R6 level low" : "R5 level", {31'd0, irq_level},
              {31'd0, !msi_mode && (|(m_sts & m_en))});
        check(irq_msg_pulse === e_pulse, "R6 pulse", {31'd0, irq_msg_pulse}, {31'd0, e_pulse});
        check(drain_retry === e_drain, "R7 retry", {31'd0, drain_retry}, {31'd0, e_drain});
        read_chk(8'h00, m_sts, req);
        read_chk(8'h04, m_en, req);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] en_pat [4];
        en_pat[0] = 32'h0; en_pat[1] = 32'h1; en_pat[2] = 32'h100; en_pat[3] = 32'hFFFF_FFFF;
        rst = 1'b1; reg_addr = 8'h00; reg_wr_en = 1'b0; reg_wdata = '0;
        cmd_status_i = 32'hA5C3_0011; cmp_event = 1'b0; msg_event = 1'b0; msi_mode = 1'b0;
        m_sts = '0; m_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        check(irq_level === 1'b0, "R1 level", {31'd0, irq_level}, 32'd0);
        check(irq_msg_pulse === 1'b0, "R1 pulse", {31'd0, irq_msg_pulse}, 32'd0);
        check(drain_retry === 1'b0, "R1 retry", {31'd0, drain_retry}, 32'd0);
        read_chk(8'h00, 32'h0, "R1 status");
        read_chk(8'h04, 32'h0, "R1 enable");

        // R8 read mux, R10 unaligned
        read_chk(8'h08, 32'hA5C3_0011, "R8 cmdstat");
        read_chk(8'h0C, 32'h0, "R8 unknown");
        read_chk(8'h01, 32'h0, "R10 unaligned read");

        // Sweep: both modes, every event pair, several enable patterns (R2..R7)
        for (int mode = 0; mode < 2; mode++) begin
            msi_mode = mode[0];
            for (int p = 0; p < 4; p++) begin
                for (int ev = 0; ev < 4; ev++) begin
                    step(1'b0, 1'b0, 1'b1, 8'h04, en_pat[p], "R4 enable");
                    step(ev[0], ev[1], 1'b0, 8'h00, 32'h0, "R2 event");
                    step(1'b0, 1'b0, 1'b1, 8'h00, 32'h0, "R7 zero write");
                    step(1'b0, 1'b0, 1'b1, 8'h00, 32'h1, "R3 partial clear");
                    step(1'b0, 1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF, "R3 full clear");
                end
            end
        end

        // R3 event wins over same-cycle clear
        msi_mode = 1'b0;
        step(1'b1, 1'b1, 1'b0, 8'h00, 32'h0, "R2 both");
        step(1'b1, 1'b0, 1'b1, 8'h00, 32'h0000_0101, "R3 event wins");
        check(m_sts == 32'h1, "R3 model", m_sts, 32'h1);
        step(1'b0, 1'b0, 1'b1, 8'h04, 32'h0000_0101, "R4 enable set");
        step(1'b0, 1'b1, 1'b0, 8'h00, 32'h0, "R5 level with both");

        // R9 writes to command status / unknown offsets do nothing
        step(1'b0, 1'b0, 1'b1, 8'h08, 32'hFFFF_FFFF, "R9 cmdstat write");
        step(1'b0, 1'b0, 1'b1, 8'h10, 32'hFFFF_FFFF, "R9 unknown write");
        // R10 unaligned writes near status and enable do nothing
        step(1'b0, 1'b0, 1'b1, 8'h01, 32'hFFFF_FFFF, "R10 unaligned status");
        step(1'b0, 1'b0, 1'b1, 8'h05, 32'h0, "R10 unaligned enable");
        read_chk(8'h08, 32'hA5C3_0011, "R9 cmdstat intact");

        // R6 message mode: repeated events give back-to-back pulses
        msi_mode = 1'b1;
        step(1'b1, 1'b0, 1'b0, 8'h00, 32'h0, "R6 pulse 1");
        step(1'b1, 1'b0, 1'b0, 8'h00, 32'h0, "R6 pulse 2");
        step(1'b0, 1'b0, 1'b0, 8'h00, 32'h0, "R6 idle no pulse");
        step(1'b0, 1'b0, 1'b1, 8'h04, 32'h0, "R6 mask off no pulse");

        // R1 reset again mid-operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_sts = '0; m_en = '0;
        #0.5;
        read_chk(8'h00, 32'h0, "R1 status after reset");
        read_chk(8'h04, 32'h0, "R1 enable after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule